// File: doc/BRIEF.md
# Brightness-Controlled Dimming PWM

This block turns a brightness reading into the duty cycle of an 8-bit pulse-width output. The output drives the high-frequency control input of a lamp driver. Samples from an external converter arrive as a value with a one-cycle valid strobe, and the block keeps the most recent one. An interval tick, nominally every 50 ms, starts each update. On the tick, the upper six bits of the held sample select an entry in a fixed descending table. That entry becomes the next pulse width.

The mapping is inverted: a higher reading gives a shorter pulse, and a shorter pulse means a brighter lamp. The duty cycle stays between about 15% and 50%. A new width waits in a shadow register and reaches the comparator only when the period counter wraps, so every period on the output is whole.

The block also watches the first sample after reset. If that sample is nearly zero, the block raises a one-cycle request that clears the lamp's elapsed-lifetime count.

Top module: `dim_pwm_ctrl`

## Requirements
- R1: The output period is 222 clock cycles. Each period has exactly one high pulse, and the pulse starts at the first cycle of the period.
- R2: Each period is high for exactly the active compare value's number of cycles. After reset the compare value is 111 (50% duty). It stays 111 until a tick occurs with a sample held, even if ticks occur before any sample.
- R3: The compare value chosen for a sample s is 111 - floor((78*i + 31)/63), where i = s[7:2]. So s=0 gives 111 and s=255 gives 33 (about 15% duty).
- R4: Samples arriving without a tick leave the duty unchanged.
- R5: A tick uses the most recent sample captured before it, whatever earlier samples there were.
- R6: A new width takes effect only at a period wrap. While a width changes, every 222-cycle window still holds exactly one rising edge.
- R7: If the first sample after reset is below 3, `life_clr` is high for exactly one cycle: the cycle after the sample's strobe.
- R8: `life_clr` stays low if the first sample is 3 or more. It also stays low for every sample after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 8 | Brightness sample |
| tick | input | 1 | Update interval pulse |
| pwm_out | output | 1 | Dimming pulse output |
| life_clr | output | 1 | Lifetime-clear request pulse |

## Verification
`life_clr` is due in the cycle that follows the sample strobe, so the bench samples it at the next falling edge and again at the one after that. A new width can reach the output up to 222 cycles after its tick, because it waits for the next wrap. The bench therefore waits 444 cycles after each tick before it counts high cycles and rising edges over one 222-cycle window. Because the duty is measured over any whole period, that count does not depend on the counter's phase. For R6, a window that starts at the tick itself must still hold exactly one rising edge.

// File: rtl/dim_pwm_ctrl.sv
module dim_pwm_ctrl #(
  parameter int SAMPLE_W   = 8,
  parameter int IDX_W      = 6,
  parameter int PWM_W      = 8,
  parameter int PERIOD     = 222,
  parameter int DUTY_MAX   = 111,
  parameter int DUTY_MIN   = 33,
  parameter int ZERO_LIMIT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                tick,
  output logic                pwm_out,
  output logic                life_clr
);
  localparam int SPAN = DUTY_MAX - DUTY_MIN;
  localparam int NIDX = (1 << IDX_W) - 1;

  function automatic logic [PWM_W-1:0] width_of(input logic [IDX_W-1:0] i);
    int v;
    v = DUTY_MAX - (SPAN * int'(i) + NIDX / 2) / NIDX;
    return PWM_W'(v);
  endfunction

  logic [IDX_W-1:0] idx_q;
  logic             have_q, first_q;
  logic [PWM_W-1:0] shadow_q, cmp_q, cnt_q;
  logic             wrap;

  assign wrap    = (cnt_q == PWM_W'(PERIOD - 1));
  assign pwm_out = (cnt_q < cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      have_q   <= 1'b0;
      first_q  <= 1'b1;
      life_clr <= 1'b0;
    end else begin
      life_clr <= smp_valid && first_q && (smp_data < SAMPLE_W'(ZERO_LIMIT));
      if (smp_valid) begin
        idx_q   <= smp_data[SAMPLE_W-1 -: IDX_W];
        have_q  <= 1'b1;
        first_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= PWM_W'(DUTY_MAX);
      cmp_q    <= PWM_W'(DUTY_MAX);
      cnt_q    <= '0;
    end else begin
      if (tick && have_q) shadow_q <= width_of(idx_q);
      if (wrap) begin
        cnt_q <= '0;
        cmp_q <= shadow_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < PWM_W'(PERIOD)); // R1
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> cnt_q == '0); // R1
  AST_CMP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_q) |-> $past(cnt_q) == PWM_W'(PERIOD - 1)); // R6
  AST_CMP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_q >= PWM_W'(DUTY_MIN) && cmp_q <= PWM_W'(DUTY_MAX)); // R2
  AST_LIFE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    life_clr |=> !life_clr); // R7
  AST_LIFE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    life_clr |-> $past(smp_valid)); // R7
endmodule

// File: tb/dim_pwm_ctrl_bench.sv
module dim_pwm_ctrl_bench;
  logic clk = 0, rst_n = 0, smp_valid = 0, tick = 0;
  logic [7:0] smp_data = 0;
  logic pwm_out, life_clr;
  int checks = 0, errors = 0;
  bit done = 0;

  dim_pwm_ctrl u_dim_pwm_ctrl (.clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_data(smp_data), .tick(tick), .pwm_out(pwm_out), .life_clr(life_clr));

  always #2 clk = ~clk;

  function automatic int exp_width(input int s);
    return 111 - (78 * (s >> 2) + 31) / 63;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int v, output int p1, output int p2);
    @(negedge clk); smp_valid = 1; smp_data = v[7:0];
    @(negedge clk); smp_valid = 0; p1 = life_clr;
    @(negedge clk); p2 = life_clr;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic window(output int highs, output int rises);
    logic prev;
    highs = 0; rises = 0;
    @(negedge clk); prev = pwm_out;
    for (int k = 0; k < 222; k++) begin
      @(negedge clk);
      if (pwm_out) highs++;
      if (pwm_out && !prev) rises++;
      prev = pwm_out;
    end
  endtask

  task automatic settle_measure(input string req, input int exp);
    int h, r;
    repeat (444) @(negedge clk);
    window(h, r);
    check(req, h, exp);
    check("R1", r, 1);
  endtask

  task automatic do_reset();
    rst_n = 0; smp_valid = 0; tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    int p1, p2, h, r, v, last;
    void'($urandom(32'd5151));
    do_reset();
    check("R7", life_clr, 0);
    settle_measure("R2", 111);
    pulse_tick();
    settle_measure("R2", 111);

    send(2, p1, p2);
    check("R7", p1, 1);
    check("R7", p2, 0);
    send(1, p1, p2);
    check("R8", p1, 0);
    settle_measure("R4", 111);
    send(255, p1, p2);
    pulse_tick();
    settle_measure("R3", 33);
    send(0, p1, p2);
    check("R8", p1, 0);
    settle_measure("R4", 33);
    pulse_tick();
    settle_measure("R3", 111);

    send(128, p1, p2);
    pulse_tick();
    window(h, r);
    check("R6", r, 1);
    settle_measure("R3", exp_width(128));

    send(40, p1, p2);
    send(200, p1, p2);
    send(100, p1, p2);
    pulse_tick();
    settle_measure("R5", exp_width(100));

    for (int n = 0; n < 20; n++) begin
      v = int'($urandom_range(0, 255));
      last = v;
      send(v, p1, p2);
      if (p1 != 0 || p2 != 0) check("R8", 1, 0);
      if ($urandom_range(0, 1) == 1) begin
        v = int'($urandom_range(0, 255));
        last = v;
        send(v, p1, p2);
      end
      pulse_tick();
      settle_measure("R3", exp_width(last));
    end

    do_reset();
    send(3, p1, p2);
    check("R8", p1, 0);
    check("R8", p2, 0);
    send(0, p1, p2);
    check("R8", p1, 0);
    settle_measure("R2", 111);

    do_reset();
    send(0, p1, p2);
    check("R7", p1, 1);
    check("R7", p2, 0);
    pulse_tick();
    settle_measure("R3", 111);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule